// File: doc/BRIEF.md
# Signed Word Divide Unit

This block is a multi-cycle execution unit for a 64-bit processor. It divides the low 32 bits of one 64-bit operand by the low 32 bits of another as signed two's-complement integers. It returns a 64-bit result that holds the 32-bit quotient with its sign bit copied into the upper half. The quotient is truncated toward zero, and the remainder is dropped.

A caller pulses `start` with both operands and the extension-enable flag present. In the normal case the unit turns both operands into magnitudes and runs a restoring shift-subtract loop that produces one quotient bit per clock. It then applies the sign and raises `done` for one cycle.

Three cases skip the loop and finish one cycle after `start`:
- A zero divisor yields all ones.
- The most negative word divided by minus one yields that most negative word, sign-extended.
- A request made with the extension disabled raises `illegal` together with `done` and leaves the result untouched.

Top module: `word_div_unit`

## Requirements
- R1: Bits 63:32 of `opa` and `opb` have no effect on the result; only bits 31:0 are used.
- R2: Whenever `done` is high and `illegal` is low, bits 63:32 of `result` all equal bit 31 of `result`.
- R3: If bits 31:0 of `opb` are zero, `result` becomes 64'hFFFF_FFFF_FFFF_FFFF and `done` is high in the cycle right after the edge that accepts `start`; `busy` stays low.
- R4: If bits 31:0 of `opa` are 32'h8000_0000 and bits 31:0 of `opb` are 32'hFFFF_FFFF, `result` becomes 64'hFFFF_FFFF_8000_0000 and `done` is high in the cycle right after the accepting edge.
- R5: In every other enabled case, `result` is the signed quotient truncated toward zero, for all four sign combinations of the operands.
- R6: If `ext_en` is low when `start` is accepted, `done` and `illegal` are both high in the cycle right after the accepting edge and `result` keeps its previous value.
- R7: In the normal case, `busy` is high from the edge that accepts `start` until the edge that raises `done`, and `done` rises on the 33rd clock edge after the accepting edge. `busy` and `done` are never high together.
- R8: A `start` presented while `busy` is high is ignored: it produces no extra `done` and does not change the result of the running division.
- R9: `done` and `illegal` are one-cycle pulses, and `result` holds its value in every cycle where `done` is low.
- R10: While reset is asserted, `busy`, `done` and `illegal` are low.
- R11: A `start` presented in the same cycle that `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse; sampled when `busy` is low |
| ext_en | input | 1 | Multiply-divide extension enable |
| opa | input | 64 | Dividend register value |
| opb | input | 64 | Divisor register value |
| busy | output | 1 | Iterative division in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse, coincident with `done` |
| result | output | 64 | Sign-extended quotient |

## Verification
A completion pulse and a fresh request can fall in the same cycle. The driver starts each request as soon as `busy` drops, so the next request's `start` lands in the cycle where the previous `done` is high. That overlap includes one-cycle bypass results followed at once by more bypass results. The scoreboard judges each overlap by matching every result in order and by the distance from its accepting edge. The bench also presents a `start` during an active loop, where an accepted request would show up as an extra, unexpected completion.

// File: rtl/wdu_pkg.sv
`timescale 1ns/1ps
package wdu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wdu_state_e;
endpackage

// File: rtl/wdu_rst_sync.sv
`timescale 1ns/1ps
module wdu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdu_classify.sv
`timescale 1ns/1ps
module wdu_classify #(
  parameter int unsigned WW = 32
) (
  input  logic [WW-1:0] dvd,
  input  logic [WW-1:0] dvs,
  output logic [WW-1:0] mag_dvd,
  output logic [WW-1:0] mag_dvs,
  output logic          neg_q,
  output logic          dvs_zero,
  output logic          ovf
);
  localparam logic [WW-1:0] MOST_NEG = {1'b1, {(WW-1){1'b0}}};

  always_comb begin
    mag_dvd  = dvd[WW-1] ? (~dvd + 1'b1) : dvd;
    mag_dvs  = dvs[WW-1] ? (~dvs + 1'b1) : dvs;
    neg_q    = dvd[WW-1] ^ dvs[WW-1];
    dvs_zero = (dvs == '0);
    ovf      = (dvd == MOST_NEG) && (dvs == '1);
  end
endmodule

// File: rtl/wdu_step.sv
`timescale 1ns/1ps
module wdu_step #(
  parameter int unsigned WW = 32
) (
  input  logic [WW-1:0] rem_i,
  input  logic [WW-1:0] quo_i,
  input  logic [WW-1:0] dvs_i,
  output logic [WW-1:0] rem_o,
  output logic [WW-1:0] quo_o
);
  logic [WW:0]   shifted;
  logic [WW+1:0] trial;
  logic          fits;

  always_comb begin
    shifted = {rem_i, quo_i[WW-1]};
    trial   = {1'b0, shifted} - {2'b00, dvs_i};
    fits    = ~trial[WW+1];
    rem_o   = fits ? trial[WW-1:0] : shifted[WW-1:0];
    quo_o   = {quo_i[WW-2:0], fits};
  end
endmodule

// File: rtl/wdu_fmt.sv
`timescale 1ns/1ps
module wdu_fmt #(
  parameter int unsigned WW = 32,
  parameter int unsigned XW = 64
) (
  input  logic [WW-1:0] quo_i,
  input  logic          neg_i,
  output logic [XW-1:0] res_o
);
  logic [WW-1:0] q_signed;

  always_comb begin
    q_signed = neg_i ? (~quo_i + 1'b1) : quo_i;
    res_o    = {{(XW-WW){q_signed[WW-1]}}, q_signed};
  end
endmodule

// File: rtl/word_div_unit.sv
`timescale 1ns/1ps
module word_div_unit #(
  parameter int unsigned XW = 64,
  parameter int unsigned WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ext_en,
  input  logic [XW-1:0] opa,
  input  logic [XW-1:0] opb,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic [XW-1:0] result
);
  import wdu_pkg::*;

  localparam int unsigned CW = $clog2(WW);
  localparam logic [CW-1:0] LAST_IT = CW'(WW - 1);
  localparam logic [XW-1:0] OVF_RES = {{(XW-WW+1){1'b1}}, {(WW-1){1'b0}}};

  logic rst_sync_n;

  wdu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Upper halves are deliberately discarded.
  logic unused_hi;
  assign unused_hi = ^{opa[XW-1:WW], opb[XW-1:WW]};

  logic [WW-1:0] mag_dvd, mag_dvs;
  logic          neg_in, dvs_zero, ovf;

  wdu_classify #(.WW(WW)) u_cls (
    .dvd      (opa[WW-1:0]),
    .dvs      (opb[WW-1:0]),
    .mag_dvd  (mag_dvd),
    .mag_dvs  (mag_dvs),
    .neg_q    (neg_in),
    .dvs_zero (dvs_zero),
    .ovf      (ovf)
  );

  wdu_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic          neg_q, neg_d;
  logic [XW-1:0] res_q, res_d;
  logic          done_q, done_d, ill_q, ill_d;
  logic          dp_en, res_en;

  logic [WW-1:0] step_rem, step_quo;
  logic [XW-1:0] fmt_res;

  wdu_step #(.WW(WW)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dvs_i (dvs_q),
    .rem_o (step_rem),
    .quo_o (step_quo)
  );

  wdu_fmt #(.WW(WW), .XW(XW)) u_fmt (
    .quo_i (quo_q),
    .neg_i (neg_q),
    .res_o (fmt_res)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    neg_d   = neg_q;
    res_d   = res_q;
    done_d  = 1'b0;
    ill_d   = 1'b0;
    dp_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (!ext_en) begin
            ill_d  = 1'b1;
            done_d = 1'b1;
          end else if (dvs_zero) begin
            res_d  = '1;
            done_d = 1'b1;
          end else if (ovf) begin
            res_d  = OVF_RES;
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            cnt_d   = '0;
            rem_d   = '0;
            quo_d   = mag_dvd;
            dvs_d   = mag_dvs;
            neg_d   = neg_in;
            dp_en   = 1'b1;
          end
        end
      end
      ST_RUN: begin
        rem_d = step_rem;
        quo_d = step_quo;
        cnt_d = cnt_q + 1'b1;
        dp_en = 1'b1;
        if (cnt_q == LAST_IT) state_d = ST_FIN;
      end
      ST_FIN: begin
        res_d   = fmt_res;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    res_en = done_d && !ill_d;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      neg_q <= 1'b0;
    end else if (dp_en) begin
      cnt_q <= cnt_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
      neg_q <= neg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign illegal = ill_q;
  assign result  = res_q;
endmodule

// File: rtl/wdu_chk.sv
`timescale 1ns/1ps
module wdu_chk #(
  parameter int unsigned XW = 64,
  parameter int unsigned WW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ext_en,
  input logic [WW-1:0] dvd_lo,
  input logic [WW-1:0] dvs_lo,
  input logic          busy,
  input logic          done,
  input logic          illegal,
  input logic [XW-1:0] result
);
  localparam logic [WW-1:0] MOST_NEG = {1'b1, {(WW-1){1'b0}}};
  localparam logic [XW-1:0] OVF_RES  = {{(XW-WW+1){1'b1}}, {(WW-1){1'b0}}};

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  disabled_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !ext_en) |=> (done && illegal));

  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(result));

  // R3
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ext_en && dvs_lo == '0) |=> (done && !busy && result == '1));

  // R4
  ovf_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ext_en && dvd_lo == MOST_NEG && dvs_lo == '1)
      |=> (done && result == OVF_RES));

  // R9
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R9
  ill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R2
  sext_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (result[XW-1:WW] == {(XW-WW){result[WW-1]}}));
endmodule

bind word_div_unit wdu_chk #(.XW(XW), .WW(WW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start),
  .ext_en  (ext_en),
  .dvd_lo  (opa[WW-1:0]),
  .dvs_lo  (opb[WW-1:0]),
  .busy    (busy),
  .done    (done),
  .illegal (illegal),
  .result  (result)
);

// File: tb/sim_word_div_unit.sv
`timescale 1ns/1ps
module sim_word_div_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ext_en = 1'b1;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        busy, done, illegal;
  logic [63:0] result;

  word_div_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_en(ext_en),
    .opa(opa), .opb(opb), .busy(busy), .done(done),
    .illegal(illegal), .result(result)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    int          lat;
    int          t0;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;
  logic [63:0] last_exp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b);
    logic signed [31:0] x, y, q;
    x = a[31:0];
    y = b[31:0];
    if (y == 0) return '1;
    if (x == 32'sh8000_0000 && y == -32'sd1) return 64'hFFFF_FFFF_8000_0000;
    q = x / y;
    return {{32{q[31]}}, q};
  endfunction

  // Driver: called at a negedge; waits for idle, pulses start, queues expectation.
  task automatic do_op(input logic [63:0] a, input logic [63:0] b, input logic en,
                       input string tag);
    item_t it;
    while (busy) @(negedge clk);
    opa = a; opb = b; ext_en = en; start = 1'b1;
    @(posedge clk);
    #1;
    it.tag = tag;
    it.t0  = cyc;
    if (!en) begin
      it.res = last_exp; it.ill = 1'b1; it.lat = 0;
    end else begin
      it.res = model(a, b); it.ill = 1'b0;
      if (b[31:0] == 0 || (a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF))
        it.lat = 0;
      else
        it.lat = 33;
      last_exp = it.res;
    end
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected done", result, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(result == it.res, {it.tag, " result"}, result, it.res);
        chk(illegal == it.ill, {it.tag, " illegal"}, 64'(illegal), 64'(it.ill));
        chk((cyc - it.t0) == it.lat, {it.tag, " latency R7"}, 64'(cyc - it.t0), 64'(it.lat));
        chk(!busy, "R7 busy with done", 64'(busy), 64'd0);
      end
    end
  end

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(!busy && !done && !illegal, "R10 reset outputs", {61'd0, busy, done, illegal}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !illegal, "R10 after release", {61'd0, busy, done, illegal}, '0);

    do_op(64'd100, 64'd7, 1'b1, "R5 pos/pos");
    do_op(-64'sd100, 64'd7, 1'b1, "R5 neg/pos R2");
    do_op(64'd100, -64'sd7, 1'b1, "R5 pos/neg");
    do_op(-64'sd100, -64'sd7, 1'b1, "R5 neg/neg");
    do_op(64'd7, 64'd100, 1'b1, "R5 small dividend");
    do_op(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_FFFF_FFF9, 1'b1, "R1 upper ignored");
    do_op(64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, 1'b1, "R5 max/min");
    do_op(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b1, "R5 min/min");
    do_op(64'h0000_0000_8000_0000, 64'd1, 1'b1, "R2 min/1");
    do_op(64'h0000_0000_8000_0000, 64'd2, 1'b1, "R5 min/2");
    // R3, R4, R6 and R11: bypass results issued back-to-back in done cycles
    do_op(64'd12345, 64'hFFFF_0000_0000_0000, 1'b1, "R3 zero divisor R11");
    do_op(64'h0000_0001_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b1, "R4 overflow R11");
    do_op(64'd55, 64'd5, 1'b0, "R6 disabled R11");
    do_op(64'd0, 64'd0, 1'b1, "R3 zero by zero R11");
    do_op(64'd55, 64'd0, 1'b0, "R6 disabled over zero");
    // R8: extra start while busy must be dropped
    do_op(64'd1000, 64'd3, 1'b1, "R8 running op");
    repeat (5) @(negedge clk);
    opa = 64'd9; opb = 64'd0; ext_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 3 == 0) b[31:0] = b[31:0] >> (i + 8);
      do_op(a, b, 1'b1, "R5 random R1");
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    // R9
    chk(!done && result == last_exp, "R9 hold after done", result, last_exp);
    chk(sb.size() == 0, "R8 pending items", 64'(sb.size()), 64'd0);
    summary();
    $finish;
  end
endmodule